// File: doc/BRIEF.md
# Write-Protected Processor Mode Registers

This block holds two byte-wide system control registers on a simple peripheral bus. Software uses them to request a device reset, to open the data-ROM area, to turn on memory wait states, and to choose whether a watchdog timeout becomes an interrupt or a reset. A write reaches either register only while an external unlock input, driven by a separate protect register, is high. Without it, all writes are dropped.

The first register, at byte address 0x04, holds no state. A 1 written to its bit 3 makes the block pulse a reset request for one cycle. The chip's reset controller is expected to answer that pulse by asserting the block's reset input. The second register, at byte address 0x05, holds three control bits. Its watchdog-reset select bit is one-way: software can set it, and only a device reset clears it. The block routes a watchdog timeout strobe to the interrupt output or to the reset output according to that bit.

Top module: `pmode_regs`

## Requirements
- R1: While `rst_n` is low and just after it is released, `drom_en`, `wait_en`, `wdt_mode_rst` and `sw_reset_req` are 0, and reads of 0x04 and 0x05 return 0x00.
- R2: A write with `wr_unlock` low changes neither register and raises no reset request.
- R3: A write to 0x05 with `wr_unlock` high loads bit 0 into the data-ROM enable (1 = enabled). `drom_en` follows it and bit 0 of a read of 0x05 shows it.
- R4: A write to 0x05 with `wr_unlock` high loads bit 7 into the wait enable (1 = wait). `wait_en` follows it and bit 7 of a read of 0x05 shows it.
- R5: Bit 2 of 0x05 selects the watchdog action (0 = interrupt, 1 = reset). An unlocked write of 1 sets it. A later write of 0 leaves it at 1, and only `rst_n` clears it. `wdt_mode_rst` follows it.
- R6: An unlocked write to 0x04 with bit 3 set raises `sw_reset_req` for exactly one cycle, in the cycle after the write's clock edge. If bit 3 is clear, the request stays low.
- R7: Every bit of 0x04, and bits 1 and 3 to 6 of 0x05, read as 0 whatever value was written.
- R8: When `wdt_timeout` is high, exactly one of `wdt_irq` (select = 0) and `wdt_rst` (select = 1) is high in the same cycle. When `wdt_timeout` is low, both are low.
- R9: A read of any address other than 0x04 and 0x05 returns 0x00, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| wr_unlock | input | 1 | Write-enable from the protect register |
| wdt_timeout | input | 1 | One-cycle watchdog timeout strobe |
| sw_reset_req | output | 1 | One-cycle software reset request |
| drom_en | output | 1 | Data-ROM area access enable |
| wait_en | output | 1 | Wait-state enable |
| wdt_mode_rst | output | 1 | Watchdog action select, 1 = reset |
| wdt_irq | output | 1 | Watchdog timeout routed as an interrupt |
| wdt_rst | output | 1 | Watchdog timeout routed as a reset |

## Verification
Some properties hold on every clock cycle, and the assertions check those:
- Locked writes leave the control outputs unchanged.
- The watchdog-reset select never falls while reset is high.
- Every reset request traces back to an unlocked write of bit 3 to 0x04.
- A timeout goes to exactly one output.
- Reads of 0x04 and of unmapped addresses are zero.

Other behaviour depends on the data written, so only the bench scenarios can show it:
- Each writable bit loads the correct value across all 256 data patterns.
- Once the select bit is set, it survives a later write of 0.
- A reset request follows bit 3 for every pattern and stays low when bit 3 is clear.
- Writes to each of the 254 other addresses leave the registers alone.

// File: rtl/pmode_regs.sv
module pmode_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG0_ADDR = 8'h04,
  parameter logic [AW-1:0] REG1_ADDR = 8'h05,
  parameter int SWRST_BIT = 3,
  parameter int DROM_BIT  = 0,
  parameter int WDSEL_BIT = 2,
  parameter int WAIT_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wr_unlock,
  input  logic          wdt_timeout,
  output logic          sw_reset_req,
  output logic          drom_en,
  output logic          wait_en,
  output logic          wdt_mode_rst,
  output logic          wdt_irq,
  output logic          wdt_rst
);

  logic wr_ok, hit0, hit1;
  logic drom_q, wait_q, wdsel_q, swrst_q;
  logic [DW-1:0] ctl_view;
  logic unused_wdata;

  assign wr_ok = bus_wr & wr_unlock;
  assign hit0  = (bus_addr == REG0_ADDR);
  assign hit1  = (bus_addr == REG1_ADDR);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drom_q  <= 1'b0;
      wait_q  <= 1'b0;
      wdsel_q <= 1'b0;
      swrst_q <= 1'b0;
    end else begin
      swrst_q <= wr_ok & hit0 & bus_wdata[SWRST_BIT];
      if (wr_ok && hit1) begin
        drom_q <= bus_wdata[DROM_BIT];
        wait_q <= bus_wdata[WAIT_BIT];
        if (bus_wdata[WDSEL_BIT]) wdsel_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl_view            = '0;
    ctl_view[DROM_BIT]  = drom_q;
    ctl_view[WDSEL_BIT] = wdsel_q;
    ctl_view[WAIT_BIT]  = wait_q;
  end

  assign bus_rdata    = hit1 ? ctl_view : '0;
  assign sw_reset_req = swrst_q;
  assign drom_en      = drom_q;
  assign wait_en      = wait_q;
  assign wdt_mode_rst = wdsel_q;
  assign wdt_irq      = wdt_timeout & ~wdsel_q;
  assign wdt_rst      = wdt_timeout &  wdsel_q;

endmodule

// File: rtl/pmode_regs_sva.sv
module pmode_regs_sva #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG0_ADDR = 8'h04,
  parameter logic [AW-1:0] REG1_ADDR = 8'h05,
  parameter int SWRST_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          wr_unlock,
  input logic          wdt_timeout,
  input logic          sw_reset_req,
  input logic          drom_en,
  input logic          wait_en,
  input logic          wdt_mode_rst,
  input logic          wdt_irq,
  input logic          wdt_rst
);

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && wr_unlock) |=> $stable({drom_en, wait_en, wdt_mode_rst})); // R2

  AST_WDSEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_mode_rst |=> wdt_mode_rst); // R5

  AST_SWRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_reset_req) |-> $past(bus_wr && wr_unlock && bus_addr == REG0_ADDR && bus_wdata[SWRST_BIT])); // R6

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG0_ADDR) |-> (bus_rdata == '0)); // R7

  AST_WDT_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> ($countones({wdt_irq, wdt_rst}) == 1 && wdt_rst == wdt_mode_rst)); // R8

  AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_timeout |-> (!wdt_irq && !wdt_rst)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG0_ADDR && bus_addr != REG1_ADDR) |-> (bus_rdata == '0)); // R9

endmodule

bind pmode_regs pmode_regs_sva #(
  .AW(AW), .DW(DW), .REG0_ADDR(REG0_ADDR), .REG1_ADDR(REG1_ADDR), .SWRST_BIT(SWRST_BIT)
) u_pmode_regs_sva (.*);

// File: tb/pmode_regs_bench.sv
`timescale 1ns/1ps
module pmode_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wr_unlock = 1'b0;
  logic       wdt_timeout = 1'b0;
  logic       sw_reset_req, drom_en, wait_en, wdt_mode_rst, wdt_irq, wdt_rst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp1;

  always #10 clk = ~clk;

  pmode_regs u_pmode_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
    .wdt_timeout(wdt_timeout), .sw_reset_req(sw_reset_req), .drom_en(drom_en),
    .wait_en(wait_en), .wdt_mode_rst(wdt_mode_rst), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic unl);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; wr_unlock = unl; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic chk_ctl(input logic [7:0] e, input string tag);
    chk({5'b0, drom_en, wait_en, wdt_mode_rst}, {5'b0, e[0], e[7], e[2]}, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk({4'b0, sw_reset_req, drom_en, wait_en, wdt_mode_rst}, 8'h00, "R1 outputs during reset");
    do_reset();
    chk({4'b0, sw_reset_req, drom_en, wait_en, wdt_mode_rst}, 8'h00, "R1 outputs after reset");
    rd(8'h04, 8'h00, "R1 read 0x04");
    rd(8'h05, 8'h00, "R1 read 0x05");

    // R2: locked writes of every pattern to both registers
    for (int d = 0; d < 256; d++) begin
      wr(8'h05, d[7:0], 1'b0);
      rd(8'h05, 8'h00, "R2 locked write 0x05");
      wr(8'h04, d[7:0], 1'b0);
      chk({7'b0, sw_reset_req}, 8'h00, "R2 locked write 0x04 request");
    end
    chk_ctl(8'h00, "R2 outputs after locked sweep");

    // R3 R4 R5 R7: unlocked sweep of 0x05, model computed in bench
    exp1 = 8'h00;
    for (int d = 0; d < 256; d++) begin
      wr(8'h05, d[7:0], 1'b1);
      exp1 = (d[7:0] & 8'h81) | (exp1 & 8'h04) | (d[7:0] & 8'h04);
      rd(8'h05, exp1, "R3 R4 R5 R7 read 0x05");
      chk_ctl(exp1, "R3 R4 R5 output pins");
    end
    wr(8'h05, 8'h00, 1'b1);
    rd(8'h05, 8'h04, "R5 select stays set after write of 0");
    do_reset();
    rd(8'h05, 8'h00, "R5 select cleared by reset");

    // R6 R7: software reset request for every pattern
    for (int d = 0; d < 256; d++) begin
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = d[7:0]; wr_unlock = 1'b1; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; wr_unlock = 1'b0;
      chk({7'b0, sw_reset_req}, {7'b0, d[3]}, "R6 request after write");
      rd(8'h04, 8'h00, "R7 read 0x04");
      @(negedge clk);
      chk({7'b0, sw_reset_req}, 8'h00, "R6 request one cycle");
    end

    // R9: other addresses
    do_reset();
    for (int a = 0; a < 256; a++) begin
      if (a != 4 && a != 5) begin
        wr(a[7:0], 8'hFF, 1'b1);
        chk({7'b0, sw_reset_req}, 8'h00, "R9 no request");
        rd(a[7:0], 8'h00, "R9 unmapped read");
      end
    end
    rd(8'h05, 8'h00, "R9 0x05 untouched");
    chk_ctl(8'h00, "R9 outputs untouched");

    // R8: watchdog routing for both selections
    @(negedge clk); #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h00, "R8 idle select 0");
    wdt_timeout = 1'b1; #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h02, "R8 timeout to interrupt");
    @(negedge clk); wdt_timeout = 1'b0; #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h00, "R8 strobe ends");
    wr(8'h05, 8'h04, 1'b1);
    #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h00, "R8 idle select 1");
    wdt_timeout = 1'b1; #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h01, "R8 timeout to reset");
    @(negedge clk); wdt_timeout = 1'b0; #1;
    chk({6'b0, wdt_irq, wdt_rst}, 8'h00, "R8 strobe ends select 1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule